// File: doc/BRIEF.md
# Line Activity Detector and Network-Side Status Word

This block builds the read-only 8-bit status word that a network-termination line interface presents to its controller. It watches the received line symbols, one per `bit_valid` strobe, and keeps an activity flag. A burst of zeros inside a short window sets the flag. A long unbroken run of ones clears it.

The top status bit reports one of two things. While an activation is being requested and no deactivation is requested, it reports frame synchronisation. In every other case it reports line activity. The rest of the word carries a two-bit activation state code, a maintenance-channel bit and a fixed all-ones nibble.

The word is sampled into an output register only on the backplane frame strobe `frame_tick`. Any number of reads between two strobes therefore return the same value.

Top module: `nt_status_unit`

## Requirements
- R1: When the third received zero (`rx_bit`=0 with `bit_valid`=1) falls inside the current 48-bit window, the activity flag is set at that clock edge.
- R2: The zero count covers consecutive blocks of 48 received bits. A block restarts after its 48th bit or right after a set, so two zeros in one block and one zero in the next do not set activity.
- R3: The 128th consecutive received one clears the activity flag at that clock edge.
- R4: Any received zero restarts the count of consecutive ones from zero.
- R5: Status bit 7 equals `frame_synced` when `deact_req`=0 and `act_req`=1. Otherwise it equals the activity flag.
- R6: Status bits 6:5 carry `state_code`: 00 deactivated, 01 pending deactivation, 10 pending activation, 11 activated.
- R7: Status bit 4 equals `maint_bit` when `multiframe_en`=1, and reads 1 when `multiframe_en`=0.
- R8: Status bits 3:0 always read 1111.
- R9: `status_word` changes only on the clock edge at which `frame_tick`=1. Between strobes it holds its value whatever the other inputs do.
- R10: After a synchronous reset `status_word` is 8'h1F, activity is clear, and both bit counters are empty.
- R11: A frame strobe in the same cycle as an activity-changing bit captures the activity value from before that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | A received line bit is present this cycle |
| rx_bit | input | 1 | Received line bit value |
| frame_tick | input | 1 | Backplane frame strobe; captures the status word |
| deact_req | input | 1 | Deactivation request |
| act_req | input | 1 | Activation request |
| frame_synced | input | 1 | Receiver frame synchronisation achieved |
| state_code | input | 2 | Activation state code |
| multiframe_en | input | 1 | Multiframing in use |
| maint_bit | input | 1 | Received maintenance-channel bit |
| status_word | output | 8 | Captured status word |

## Verification
The frame capture and the activity update can land on the same clock edge. The third zero of a window, or the 128th one of a run, can arrive while `frame_tick` is high. The bench holds the strobe high on every cycle while it sends these bits. It then expects the word captured at that edge to show the old activity value and the following capture to show the new one. A behavioural reference model, fed the same bit stream, is compared with the output on every clock.

// File: rtl/nt_stat_pkg.sv
// Package: shared sizes and the status word layout for the status unit.
// Assumes: one received bit per bit_valid strobe; the frame strobe is one cycle wide.
package nt_stat_pkg;
    localparam int WIN_BITS_DEF  = 48;
    localparam int ZERO_HITS_DEF = 3;
    localparam int ONE_RUN_DEF   = 128;

    typedef struct packed {
        logic       top_flag;   // bit 7: sync or activity
        logic [1:0] state;      // bits 6:5
        logic       maint;      // bit 4
        logic [3:0] fill;       // bits 3:0, always ones
    } stat_word_t;

    localparam stat_word_t STAT_RESET = '{top_flag: 1'b0, state: 2'b00,
                                          maint: 1'b1, fill: 4'hF};
endpackage

// File: rtl/zero_window_det.sv
// zero_window_det: counts received zeros inside consecutive blocks of WIN_BITS bits.
// It raises hit_o combinationally on the bit that brings the count to ZERO_HITS.
// Assumes: bits arrive with bit_valid_i; a hit restarts the block.
module zero_window_det #(
    parameter int WIN_BITS  = 48,
    parameter int ZERO_HITS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid_i,
    input  logic rx_bit_i,
    output logic hit_o
);
    localparam int PW = $clog2(WIN_BITS);
    localparam int ZW = $clog2(ZERO_HITS + 1);
    localparam logic [PW-1:0] POS_LAST  = PW'(WIN_BITS - 1);
    localparam logic [ZW-1:0] ZERO_LAST = ZW'(ZERO_HITS - 1);

    logic [PW-1:0] pos_q;
    logic [ZW-1:0] zeros_q;

    // Third-zero detection for the current block.
    always_comb begin
        hit_o = bit_valid_i && !rx_bit_i && (zeros_q == ZERO_LAST);
    end

    // Block position and zero count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            zeros_q <= '0;
        end else if (bit_valid_i) begin
            if (hit_o || pos_q == POS_LAST) begin
                pos_q   <= '0;
                zeros_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
                if (!rx_bit_i) zeros_q <= zeros_q + 1'b1;
            end
        end
    end

    assert_block_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_i && pos_q == POS_LAST) |=> (zeros_q == '0 && pos_q == '0));
endmodule

// File: rtl/ones_run_det.sv
// ones_run_det: counts consecutive received ones, saturating at ONE_RUN.
// It raises clr_o on the bit that completes the run.
// Assumes: any received zero restarts the run.
module ones_run_det #(
    parameter int ONE_RUN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid_i,
    input  logic rx_bit_i,
    output logic clr_o
);
    localparam int RW = $clog2(ONE_RUN + 1);
    localparam logic [RW-1:0] RUN_MAX  = RW'(ONE_RUN);
    localparam logic [RW-1:0] RUN_LAST = RW'(ONE_RUN - 1);

    logic [RW-1:0] run_q;

    // Completion pulse on the final one of the run.
    always_comb begin
        clr_o = bit_valid_i && rx_bit_i && (run_q == RUN_LAST);
    end

    // Saturating run counter, restarted by zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_valid_i) begin
            if (!rx_bit_i)             run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        end
    end

    assert_zero_restarts_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_i && !rx_bit_i) |=> (run_q == '0));
endmodule

// File: rtl/status_capture.sv
// status_capture: assembles the status word and registers it on each frame strobe.
// Assumes: activity_i is already registered; the word holds between strobes.
module status_capture
    import nt_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_tick_i,
    input  logic       deact_req_i,
    input  logic       act_req_i,
    input  logic       frame_synced_i,
    input  logic       activity_i,
    input  logic [1:0] state_code_i,
    input  logic       multiframe_en_i,
    input  logic       maint_bit_i,
    output stat_word_t word_o
);
    stat_word_t next_w;

    // Field selection for the next captured word.
    always_comb begin
        next_w.top_flag = (!deact_req_i && act_req_i) ? frame_synced_i : activity_i;
        next_w.state    = state_code_i;
        next_w.maint    = multiframe_en_i ? maint_bit_i : 1'b1;
        next_w.fill     = 4'hF;
    end

    // Once-per-frame capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)            word_o <= STAT_RESET;
        else if (frame_tick_i) word_o <= next_w;
    end

    assert_hold_between_frames_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick_i |=> $stable(word_o));
    assert_sync_shown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick_i && !deact_req_i && act_req_i) |=> (word_o.top_flag == $past(frame_synced_i)));
    assert_state_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick_i |=> (word_o.state == $past(state_code_i)));
    assert_maint_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick_i && !multiframe_en_i) |=> word_o.maint);
endmodule

// File: rtl/nt_status_unit.sv
// nt_status_unit: line activity flag plus the once-per-frame status word.
// A zero burst sets activity; a long run of ones clears it. The word is captured on frame_tick.
// Assumes: synchronous active-low reset; set and clear never coincide, because they need opposite bits.
module nt_status_unit
    import nt_stat_pkg::*;
#(
    parameter int WIN_BITS  = WIN_BITS_DEF,
    parameter int ZERO_HITS = ZERO_HITS_DEF,
    parameter int ONE_RUN   = ONE_RUN_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid,
    input  logic       rx_bit,
    input  logic       frame_tick,
    input  logic       deact_req,
    input  logic       act_req,
    input  logic       frame_synced,
    input  logic [1:0] state_code,
    input  logic       multiframe_en,
    input  logic       maint_bit,
    output logic [7:0] status_word
);
    logic       zero_hit;
    logic       run_done;
    logic       activity_q;
    stat_word_t word;

    zero_window_det #(.WIN_BITS(WIN_BITS), .ZERO_HITS(ZERO_HITS)) zwin_i (
        .clk(clk), .rst_n(rst_n), .bit_valid_i(bit_valid), .rx_bit_i(rx_bit),
        .hit_o(zero_hit));

    ones_run_det #(.ONE_RUN(ONE_RUN)) orun_i (
        .clk(clk), .rst_n(rst_n), .bit_valid_i(bit_valid), .rx_bit_i(rx_bit),
        .clr_o(run_done));

    // Activity flag: set by the zero burst, cleared by the completed ones run.
    always_ff @(posedge clk) begin
        if (!rst_n)        activity_q <= 1'b0;
        else if (zero_hit) activity_q <= 1'b1;
        else if (run_done) activity_q <= 1'b0;
    end

    status_capture cap_i (
        .clk(clk), .rst_n(rst_n), .frame_tick_i(frame_tick),
        .deact_req_i(deact_req), .act_req_i(act_req), .frame_synced_i(frame_synced),
        .activity_i(activity_q), .state_code_i(state_code),
        .multiframe_en_i(multiframe_en), .maint_bit_i(maint_bit), .word_o(word));

    // Output mapping of the captured word.
    always_comb begin
        status_word = word;
    end

    assert_set_on_third_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        zero_hit |=> activity_q);
    assert_clear_on_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> !activity_q);
    assert_old_value_captured_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && deact_req) |=> (status_word[7] == $past(activity_q)));
endmodule

// File: tb/nt_status_unit_tb_top.sv
module nt_status_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0, rx_bit = 1'b1, frame_tick = 1'b1;
    logic deact_req = 1'b1, act_req = 1'b0, frame_synced = 1'b0;
    logic [1:0] state_code = 2'b00;
    logic multiframe_en = 1'b0, maint_bit = 1'b0;
    logic [7:0] status_word;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nt_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
        .frame_tick(frame_tick), .deact_req(deact_req), .act_req(act_req),
        .frame_synced(frame_synced), .state_code(state_code),
        .multiframe_en(multiframe_en), .maint_bit(maint_bit),
        .status_word(status_word));

    // Behavioural reference model
    int m_pos, m_zeros, m_run;
    bit m_act;
    logic [7:0] m_word;

    function automatic logic [7:0] compose(input bit act);
        logic top;
        top = (!deact_req && act_req) ? frame_synced : act;
        return {top, state_code, (multiframe_en ? maint_bit : 1'b1), 4'b1111};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_zeros = 0; m_run = 0; m_act = 0; m_word = 8'h1F;
        end else begin
            if (frame_tick) m_word = compose(m_act);
            if (bit_valid) begin
                if (rx_bit) begin
                    if (m_run < 128) begin
                        m_run++;
                        if (m_run == 128) m_act = 0;
                    end
                end else begin
                    m_run = 0;
                    m_zeros++;
                end
                m_pos++;
                if (m_zeros == 3) begin
                    m_act = 1; m_pos = 0; m_zeros = 0;
                end else if (m_pos == 48) begin
                    m_pos = 0; m_zeros = 0;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison against the model, field by field
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 top bit",    {7'd0, status_word[7]},   {7'd0, m_word[7]});
            check("R6 state",      {6'd0, status_word[6:5]}, {6'd0, m_word[6:5]});
            check("R7 maint",      {7'd0, status_word[4]},   {7'd0, m_word[4]});
            check("R8 fill",       {4'd0, status_word[3:0]}, {4'd0, m_word[3:0]});
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_valid = 1'b1; rx_bit = b;
        @(posedge clk); #1;
        bit_valid = 1'b0; rx_bit = 1'b1;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    logic [7:0] held;
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R10 reset word", status_word, 8'h1F);
        // Activity shown on bit 7 (deact_req=1), strobe every cycle
        send_bit(0); send_bit(0);
        for (int i = 0; i < 46; i++) send_bit(1);
        send_bit(0);
        idle_cycle();
        check("R2 zeros split across blocks", {7'd0, status_word[7]}, 8'd0);
        send_bit(0);
        send_bit(0);
        check("R11 capture sees old activity", {7'd0, status_word[7]}, 8'd0);
        idle_cycle();
        check("R1 set on third zero", {7'd0, status_word[7]}, 8'd1);
        for (int i = 0; i < 100; i++) send_bit(1);
        send_bit(0);
        for (int i = 0; i < 127; i++) send_bit(1);
        idle_cycle();
        check("R4 run restarted by zero", {7'd0, status_word[7]}, 8'd1);
        send_bit(1);
        check("R11 capture before clear", {7'd0, status_word[7]}, 8'd1);
        idle_cycle();
        check("R3 clear after 128 ones", {7'd0, status_word[7]}, 8'd0);
        // R5 selection
        deact_req = 1'b0; act_req = 1'b1; frame_synced = 1'b1;
        idle_cycle();
        check("R5 sync shown", {7'd0, status_word[7]}, 8'd1);
        frame_synced = 1'b0;
        idle_cycle();
        check("R5 sync lost shown", {7'd0, status_word[7]}, 8'd0);
        // R6, R7, R8 fields
        state_code = 2'b10; multiframe_en = 1'b1; maint_bit = 1'b0;
        idle_cycle();
        check("R6 R7 fields", status_word, 8'b0100_1111);
        state_code = 2'b01; multiframe_en = 1'b0;
        idle_cycle();
        check("R7 default one", status_word, 8'b0011_1111);
        check("R8 fill ones", {4'd0, status_word[3:0]}, 8'h0F);
        // R9 hold between strobes
        frame_tick = 1'b0;
        held = status_word;
        state_code = 2'b11; frame_synced = 1'b1; multiframe_en = 1'b1;
        for (int i = 0; i < 5; i++) send_bit(0);
        check("R9 held between strobes", status_word, held);
        frame_tick = 1'b1;
        idle_cycle();
        check("R9 updated on strobe", status_word, 8'b1110_1111);
        frame_tick = 1'b0;
        idle_cycle();
        finish_run();
    end
endmodule